// File: doc/BRIEF.md
# Acquisition Pacing Sequencer

The block paces an analog-to-digital converter with two cascaded programmable timers. A slow scan timer marks the start of each scan; every scan tick launches a burst that walks a stored list of conversion entries, issuing one conversion strobe per tick of a faster conversion timer. Each strobe carries the channel number and gain code of the entry being converted. A programmed total sample count ends the run by itself, or a stop pulse ends it at once.

Software-side logic loads a small set of 16-bit parameter words and the entry list while the block is idle, then pulses `start`. The parameter index map is fixed: 0 list length, 1 conversion timer high word, 2 conversion timer low word, 3 scan timer high word, 4 scan timer low word, 5 mode word, 6 count bits 15:0, 7 count bits 23:16. The conversion timer counts base ticks of `CONV_BASE_CYC` clock cycles and the scan timer base ticks of `SCAN_BASE_CYC` cycles (the defaults keep the 1:2 ratio between the two).

Top module: `acq_pacer`

## Requirements
- R1: A timer period in clock cycles is base × (prescale + 1) × divider. After an accepted start on edge S, the first burst begins on edge S + Ps, later bursts every Ps cycles, and entry k of a burst is issued on edge (burst start) + k × Pc, where Ps and Pc are the scan and conversion periods.
- R2: A timer setting is a prescale (bits 3:0 of the high word, bits 19:16 of the 32-bit setting) and a 16-bit divider (the low word). The high word is only held; the whole setting takes effect when the low word is written, so a lone high-word write leaves the period unchanged.
- R3: A divider of 0 behaves as a divider of 1.
- R4: Every burst issues exactly list-length strobes, starting at entry 0 and stepping through the list in address order.
- R5: A list entry is 8 bits: channel number in bits 5:0, gain code in bits 7:6; each strobe presents them on `conv_chan` and `conv_gain` in the same cycle.
- R6: The trigger mode is bits 4:2 of the mode word; only the value 2 (internal retrigger) is run. A start with any other mode, or with a list length of 0 or above `LIST_DEPTH`, is ignored and `busy` stays low.
- R7: A scan tick that arrives while a burst is still running is ignored and sets `overrun`, which stays set until the next accepted start clears it.
- R8: With a count N ≠ 0 the run ends on the edge that issues strobe N, `busy` falling in the same cycle that strobe is visible; N = 0 runs until stopped.
- R9: A stop pulse clears `busy` on the next edge, no further strobes follow, and stop wins over a simultaneous start.
- R10: While `busy` is high, start pulses, parameter writes and list writes have no effect on the run.
- R11: After reset `busy`, `conv_stb` and `overrun` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| par_we | input | 1 | Parameter word write strobe |
| par_sel | input | 3 | Parameter word index |
| par_data | input | 16 | Parameter word value |
| lst_we | input | 1 | List entry write strobe |
| lst_addr | input | $clog2(LIST_DEPTH) | List entry address |
| lst_data | input | 8 | List entry: gain code and channel |
| start | input | 1 | Start pulse |
| stop | input | 1 | Stop pulse |
| busy | output | 1 | Run in progress |
| conv_stb | output | 1 | One-cycle conversion strobe |
| conv_chan | output | 6 | Channel of the current conversion |
| conv_gain | output | 2 | Gain code of the current conversion |
| overrun | output | 1 | Sticky scan overrun flag |

## Verification
Random configurations vary list length, both prescales and dividers and the sample count, with the scan period always long enough for a burst; these separate errors in the period product, the burst start point, entry order and the stop edge, because each strobe is compared against a cycle-exact prediction. Directed cases use a lone high-word write and a zero divider to tell atomic loading and divider handling apart from a plain period error, and a scan period shorter than a burst to show overrun being flagged while the running burst and the next accepted scan stay intact. Rejected starts, a stop colliding with a start, and writes injected mid-run show which inputs must leave the outputs untouched.

// File: rtl/acq_pacer_pkg.sv
package acq_pacer_pkg;
  localparam int PRE_W  = 4;
  localparam int DIV_W  = 16;
  localparam int PAR_W  = 16;
  localparam int CNT_W  = 24;
  localparam int CHAN_W = 6;
  localparam int GAIN_W = 2;
  localparam int ENT_W  = CHAN_W + GAIN_W;

  typedef enum logic [2:0] {
    PAR_LEN     = 3'd0,
    PAR_CONV_HI = 3'd1,
    PAR_CONV_LO = 3'd2,
    PAR_SCAN_HI = 3'd3,
    PAR_SCAN_LO = 3'd4,
    PAR_MODE    = 3'd5,
    PAR_CNT_LO  = 3'd6,
    PAR_CNT_HI  = 3'd7
  } par_idx_e;

  typedef enum logic [2:0] {
    TRG_INT        = 3'd0,
    TRG_EXT        = 3'd1,
    TRG_INT_RETRIG = 3'd2,
    TRG_EXT_RETRIG = 3'd3,
    TRG_EXT_ALT    = 3'd4
  } trig_mode_e;

  typedef struct packed {
    logic [PRE_W-1:0] pre;
    logic [DIV_W-1:0] div;
  } tmr_set_t;
endpackage

// File: rtl/acq_pacer_timer.sv
module acq_pacer_timer
  import acq_pacer_pkg::*;
#(
  parameter int BASE_CYC = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     clr_i,
  input  logic     en_i,
  input  tmr_set_t set_i,
  output logic     tick_o
);
  localparam int BW = (BASE_CYC > 1) ? $clog2(BASE_CYC) : 1;
  localparam logic [BW-1:0] BASE_LAST = BW'(BASE_CYC - 1);

  logic [BW-1:0]    base_q, base_d;
  logic [PRE_W-1:0] pre_q, pre_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic [DIV_W-1:0] div_last;
  logic             base_end, pre_end, div_end;

  // a zero divider is treated as one
  assign div_last = (set_i.div == '0) ? '0 : set_i.div - DIV_W'(1);
  assign base_end = (base_q == BASE_LAST);
  assign pre_end  = (pre_q == set_i.pre);
  assign div_end  = (div_q == div_last);
  assign tick_o   = en_i & base_end & pre_end & div_end;

  always_comb begin
    base_d = base_q;
    pre_d  = pre_q;
    div_d  = div_q;
    if (clr_i) begin
      base_d = '0;
      pre_d  = '0;
      div_d  = '0;
    end else if (en_i) begin
      base_d = base_end ? '0 : base_q + BW'(1);
      if (base_end) begin
        pre_d = pre_end ? '0 : pre_q + PRE_W'(1);
        if (pre_end) div_d = div_end ? '0 : div_q + DIV_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      pre_q  <= '0;
      div_q  <= '0;
    end else if (clr_i || en_i) begin
      base_q <= base_d;
      pre_q  <= pre_d;
      div_q  <= div_d;
    end
  end

  AST_TMR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && !clr_i) |=> $stable(div_q) && $stable(pre_q)) else $error("timer moved while idle"); // R1
endmodule

// File: rtl/acq_pacer_cfg.sv
module acq_pacer_cfg
  import acq_pacer_pkg::*;
#(
  parameter int LIST_DEPTH = 512,
  localparam int LEN_W  = $clog2(LIST_DEPTH + 1),
  localparam int ADDR_W = $clog2(LIST_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy_i,
  input  logic              par_we_i,
  input  logic [2:0]        par_idx_i,
  input  logic [PAR_W-1:0]  par_wdata_i,
  input  logic              lst_we_i,
  input  logic [ADDR_W-1:0] lst_addr_i,
  input  logic [ENT_W-1:0]  lst_wdata_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [ENT_W-1:0]  rd_data_o,
  output logic [LEN_W-1:0]  list_len_o,
  output tmr_set_t          conv_set_o,
  output tmr_set_t          scan_set_o,
  output trig_mode_e        mode_o,
  output logic [CNT_W-1:0]  count_o
);
  logic [ENT_W-1:0] mem_q [LIST_DEPTH];

  logic [LEN_W-1:0] len_q, len_d;
  logic [PRE_W-1:0] conv_hi_q, conv_hi_d, scan_hi_q, scan_hi_d;
  tmr_set_t         conv_q, conv_d, scan_q, scan_d;
  trig_mode_e       mode_q, mode_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             wr_ok;

  assign wr_ok = par_we_i & ~busy_i;

  always_comb begin
    len_d     = len_q;
    conv_hi_d = conv_hi_q;
    scan_hi_d = scan_hi_q;
    conv_d    = conv_q;
    scan_d    = scan_q;
    mode_d    = mode_q;
    cnt_d     = cnt_q;
    if (wr_ok) begin
      case (par_idx_e'(par_idx_i))
        PAR_LEN:     len_d = par_wdata_i[LEN_W-1:0];
        PAR_CONV_HI: conv_hi_d = par_wdata_i[PRE_W-1:0];
        PAR_CONV_LO: conv_d = '{pre: conv_hi_q, div: par_wdata_i};
        PAR_SCAN_HI: scan_hi_d = par_wdata_i[PRE_W-1:0];
        PAR_SCAN_LO: scan_d = '{pre: scan_hi_q, div: par_wdata_i};
        PAR_MODE:    mode_d = trig_mode_e'(par_wdata_i[4:2]);
        PAR_CNT_LO:  cnt_d[15:0] = par_wdata_i;
        PAR_CNT_HI:  cnt_d[CNT_W-1:16] = par_wdata_i[CNT_W-17:0];
        default:     ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q     <= '0;
      conv_hi_q <= '0;
      scan_hi_q <= '0;
      conv_q    <= '0;
      scan_q    <= '0;
      mode_q    <= TRG_INT;
      cnt_q     <= '0;
    end else if (wr_ok) begin
      len_q     <= len_d;
      conv_hi_q <= conv_hi_d;
      scan_hi_q <= scan_hi_d;
      conv_q    <= conv_d;
      scan_q    <= scan_d;
      mode_q    <= mode_d;
      cnt_q     <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (lst_we_i && !busy_i) mem_q[lst_addr_i] <= lst_wdata_i;
  end

  assign rd_data_o  = mem_q[rd_addr_i];
  assign list_len_o = len_q;
  assign conv_set_o = conv_q;
  assign scan_set_o = scan_q;
  assign mode_o     = mode_q;
  assign count_o    = cnt_q;

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |=> $stable(len_q) && $stable(conv_q) && $stable(scan_q) && $stable(cnt_q)) else $error("config changed in run"); // R10
endmodule

// File: rtl/acq_pacer_seq.sv
module acq_pacer_seq
  import acq_pacer_pkg::*;
#(
  parameter int LIST_DEPTH = 512,
  localparam int LEN_W  = $clog2(LIST_DEPTH + 1),
  localparam int ADDR_W = $clog2(LIST_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [LEN_W-1:0]  list_len_i,
  input  trig_mode_e        mode_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              scan_tick_i,
  input  logic              conv_tick_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [ENT_W-1:0]  rd_data_i,
  output logic              busy_o,
  output logic              burst_o,
  output logic              scan_clr_o,
  output logic              conv_clr_o,
  output logic              conv_stb_o,
  output logic [CHAN_W-1:0] conv_chan_o,
  output logic [GAIN_W-1:0] conv_gain_o,
  output logic              overrun_o
);
  logic              busy_q, busy_d, burst_q, burst_d, lim_q, lim_d;
  logic              ovr_q, ovr_d, stb_q, stb_d;
  logic [ADDR_W-1:0] idx_q, idx_d;
  logic [CNT_W-1:0]  rem_q, rem_d;
  logic [CHAN_W-1:0] chan_q;
  logic [GAIN_W-1:0] gain_q;
  logic              len_ok, start_ok, burst_go, step, issue, last_ent, cnt_last;

  assign len_ok   = (list_len_i != '0) && (list_len_i <= LEN_W'(LIST_DEPTH));
  assign start_ok = start_i & ~stop_i & ~busy_q & (mode_i == TRG_INT_RETRIG) & len_ok;
  assign burst_go = busy_q & scan_tick_i & ~burst_q & ~stop_i;
  assign step     = busy_q & burst_q & conv_tick_i & ~stop_i;
  assign issue    = burst_go | step;
  assign rd_addr_o = burst_go ? '0 : idx_q;
  assign last_ent = burst_go ? (list_len_i == LEN_W'(1))
                             : (LEN_W'(idx_q) == list_len_i - LEN_W'(1));
  assign cnt_last = lim_q & (rem_q == CNT_W'(1));

  always_comb begin
    busy_d  = busy_q;
    burst_d = burst_q;
    idx_d   = idx_q;
    rem_d   = rem_q;
    lim_d   = lim_q;
    ovr_d   = ovr_q;
    stb_d   = 1'b0;
    if (stop_i) begin
      busy_d  = 1'b0;
      burst_d = 1'b0;
    end else if (start_ok) begin
      busy_d  = 1'b1;
      burst_d = 1'b0;
      idx_d   = '0;
      rem_d   = count_i;
      lim_d   = (count_i != '0);
      ovr_d   = 1'b0;
    end else if (busy_q) begin
      if (scan_tick_i && burst_q) ovr_d = 1'b1;
      if (issue) begin
        stb_d = 1'b1;
        if (last_ent) begin
          burst_d = 1'b0;
          idx_d   = '0;
        end else begin
          burst_d = 1'b1;
          idx_d   = burst_go ? ADDR_W'(1) : idx_q + ADDR_W'(1);
        end
        if (lim_q) rem_d = rem_q - CNT_W'(1);
        if (cnt_last) begin
          busy_d  = 1'b0;
          burst_d = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      burst_q <= 1'b0;
      idx_q   <= '0;
      rem_q   <= '0;
      lim_q   <= 1'b0;
      ovr_q   <= 1'b0;
      stb_q   <= 1'b0;
      chan_q  <= '0;
      gain_q  <= '0;
    end else begin
      busy_q  <= busy_d;
      burst_q <= burst_d;
      idx_q   <= idx_d;
      rem_q   <= rem_d;
      lim_q   <= lim_d;
      ovr_q   <= ovr_d;
      stb_q   <= stb_d;
      if (issue && !stop_i) begin
        chan_q <= rd_data_i[CHAN_W-1:0];
        gain_q <= rd_data_i[ENT_W-1:CHAN_W];
      end
    end
  end

  assign busy_o      = busy_q;
  assign burst_o     = burst_q;
  assign scan_clr_o  = start_ok;
  assign conv_clr_o  = burst_go;
  assign conv_stb_o  = stb_q;
  assign conv_chan_o = chan_q;
  assign conv_gain_o = gain_q;
  assign overrun_o   = ovr_q;

  AST_STOP_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> !busy_q && !burst_q) else $error("stop ignored"); // R9
  AST_IDX_IN_LIST: assert property (@(posedge clk) disable iff (!rst_n)
    burst_q |-> (LEN_W'(idx_q) < list_len_i)) else $error("index past list"); // R4
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && ovr_q) |=> ovr_q) else $error("overrun lost"); // R7
  AST_STB_FROM_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    stb_q |-> $past(busy_q)) else $error("strobe while idle"); // R8
  AST_BUSY_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> ($past(stop_i) || stb_q)) else $error("run ended without cause"); // R8
endmodule

// File: rtl/acq_pacer.sv
module acq_pacer
  import acq_pacer_pkg::*;
#(
  parameter int LIST_DEPTH    = 512,
  parameter int CONV_BASE_CYC = 2,
  parameter int SCAN_BASE_CYC = 4,
  localparam int ADDR_W = $clog2(LIST_DEPTH),
  localparam int LEN_W  = $clog2(LIST_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              par_we,
  input  logic [2:0]        par_sel,
  input  logic [PAR_W-1:0]  par_data,
  input  logic              lst_we,
  input  logic [ADDR_W-1:0] lst_addr,
  input  logic [ENT_W-1:0]  lst_data,
  input  logic              start,
  input  logic              stop,
  output logic              busy,
  output logic              conv_stb,
  output logic [CHAN_W-1:0] conv_chan,
  output logic [GAIN_W-1:0] conv_gain,
  output logic              overrun
);
  logic [ADDR_W-1:0] rd_addr;
  logic [ENT_W-1:0]  rd_data;
  logic [LEN_W-1:0]  list_len;
  tmr_set_t          conv_set, scan_set;
  trig_mode_e        mode;
  logic [CNT_W-1:0]  count;
  logic              burst, scan_clr, conv_clr, scan_tick, conv_tick;

  acq_pacer_cfg #(.LIST_DEPTH(LIST_DEPTH)) u_cfg (
    .clk(clk), .rst_n(rst_n), .busy_i(busy),
    .par_we_i(par_we), .par_idx_i(par_sel), .par_wdata_i(par_data),
    .lst_we_i(lst_we), .lst_addr_i(lst_addr), .lst_wdata_i(lst_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .list_len_o(list_len),
    .conv_set_o(conv_set), .scan_set_o(scan_set), .mode_o(mode), .count_o(count)
  );

  acq_pacer_timer #(.BASE_CYC(SCAN_BASE_CYC)) u_scan_tmr (
    .clk(clk), .rst_n(rst_n), .clr_i(scan_clr), .en_i(busy),
    .set_i(scan_set), .tick_o(scan_tick)
  );

  acq_pacer_timer #(.BASE_CYC(CONV_BASE_CYC)) u_conv_tmr (
    .clk(clk), .rst_n(rst_n), .clr_i(conv_clr), .en_i(burst),
    .set_i(conv_set), .tick_o(conv_tick)
  );

  acq_pacer_seq #(.LIST_DEPTH(LIST_DEPTH)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start), .stop_i(stop),
    .list_len_i(list_len), .mode_i(mode), .count_i(count),
    .scan_tick_i(scan_tick), .conv_tick_i(conv_tick),
    .rd_addr_o(rd_addr), .rd_data_i(rd_data),
    .busy_o(busy), .burst_o(burst), .scan_clr_o(scan_clr), .conv_clr_o(conv_clr),
    .conv_stb_o(conv_stb), .conv_chan_o(conv_chan), .conv_gain_o(conv_gain),
    .overrun_o(overrun)
  );
endmodule

// File: tb/test_acq_pacer.sv
`timescale 1ns/1ps
module test_acq_pacer;
  localparam int DEPTH = 512;
  localparam int CB = 2;
  localparam int SB = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic par_we = 1'b0;
  logic [2:0] par_sel = '0;
  logic [15:0] par_data = '0;
  logic lst_we = 1'b0;
  logic [8:0] lst_addr = '0;
  logic [7:0] lst_data = '0;
  logic start = 1'b0;
  logic stop = 1'b0;
  logic busy, conv_stb, overrun;
  logic [5:0] conv_chan;
  logic [1:0] conv_gain;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [7:0] mir [DEPTH];
  int L, Pc, Ps, N;

  always #2 clk = ~clk;

  acq_pacer #(.LIST_DEPTH(DEPTH), .CONV_BASE_CYC(CB), .SCAN_BASE_CYC(SB)) i_acq_pacer (
    .clk(clk), .rst_n(rst_n), .par_we(par_we), .par_sel(par_sel), .par_data(par_data),
    .lst_we(lst_we), .lst_addr(lst_addr), .lst_data(lst_data), .start(start), .stop(stop),
    .busy(busy), .conv_stb(conv_stb), .conv_chan(conv_chan), .conv_gain(conv_gain),
    .overrun(overrun)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic par_wr(input int idx, input int val);
    @(negedge clk);
    par_we = 1'b1; par_sel = 3'(idx); par_data = 16'(val);
    @(negedge clk);
    par_we = 1'b0;
  endtask

  task automatic fill_list(input int len);
    for (int a = 0; a < len; a++) begin
      @(negedge clk);
      mir[a] = 8'($urandom);
      lst_we = 1'b1; lst_addr = 9'(a); lst_data = mir[a];
    end
    @(negedge clk);
    lst_we = 1'b0;
  endtask

  function automatic int per(input int base, input int pre, input int dv);
    return base * (pre + 1) * ((dv == 0) ? 1 : dv);
  endfunction

  task automatic setup(input int len, input int cp, input int cd, input int sp,
                       input int sd, input int md, input int n);
    par_wr(0, len);
    par_wr(1, cp); par_wr(2, cd);
    par_wr(3, sp); par_wr(4, sd);
    par_wr(5, md << 2);
    par_wr(6, n & 16'hffff); par_wr(7, (n >> 16) & 8'hff);
    L = len; Pc = per(CB, cp, cd); Ps = per(SB, sp, sd); N = n;
  endtask

  // sequence number of the strobe expected at offset e after the start edge, or -1
  function automatic int exp_seq(input int e);
    int s, r, k, sq;
    if (e < Ps) return -1;
    s = e / Ps; r = e - s * Ps;
    if ((r % Pc) != 0) return -1;
    k = r / Pc;
    if (k >= L) return -1;
    sq = (s - 1) * L + k;
    if (N != 0 && sq >= N) return -1;
    return sq;
  endfunction

  function automatic int end_edge();
    return Ps * (1 + (N - 1) / L) + ((N - 1) % L) * Pc;
  endfunction

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  // checks every cycle of a run; poke injects a start and a list-length write while busy
  task automatic run(input string tstb, input int lim_in, input bit poke);
    int lim;
    lim = (N != 0) ? end_edge() + 6 : lim_in;
    pulse_start();
    for (int e = 0; e <= lim; e++) begin
      int sq;
      sq = exp_seq(e);
      chk(tstb, int'(conv_stb), (sq >= 0) ? 1 : 0);
      if (sq >= 0) begin
        chk("R5 chan", int'(conv_chan), int'(mir[sq % L][5:0]));
        chk("R5 gain", int'(conv_gain), int'(mir[sq % L][7:6]));
      end
      chk("R8 busy", int'(busy), (N == 0 || e < end_edge()) ? 1 : 0);
      chk("R7 no overrun", int'(overrun), 0);
      if (poke && e == 3) begin
        par_we = 1'b1; par_sel = 3'd0; par_data = 16'd1; start = 1'b1;
        lst_we = 1'b1; lst_addr = 9'd0; lst_data = ~mir[0];
      end else begin
        par_we = 1'b0; start = 1'b0; lst_we = 1'b0;
      end
      @(negedge clk);
    end
  endtask

  task automatic idle_check(input string req, input int cyc);
    for (int c = 0; c < cyc; c++) begin
      @(negedge clk);
      chk(req, int'(busy), 0);
      chk(req, int'(conv_stb), 0);
    end
  endtask

  initial begin
    #600000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'd20613);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 busy", int'(busy), 0);
    chk("R11 stb", int'(conv_stb), 0);
    chk("R11 overrun", int'(overrun), 0);

    // directed: mode other than internal retrigger is refused
    fill_list(4);
    setup(4, 0, 2, 0, 3, 0, 5);
    pulse_start();
    idle_check("R6 mode", 20);
    // directed: list length zero refused
    setup(0, 0, 2, 0, 3, 2, 5);
    pulse_start();
    idle_check("R6 length", 20);

    // random configurations, burst always fits in a scan
    for (int t = 0; t < 10; t++) begin
      int len, cp, cd, sp, sd, n, pc;
      len = 1 + int'($urandom % 5);
      cp = int'($urandom % 2); cd = 1 + int'($urandom % 4);
      pc = per(CB, cp, cd);
      sp = int'($urandom % 2);
      sd = (len * pc + SB * (sp + 1) - 1) / (SB * (sp + 1)) + int'($urandom % 2);
      n = 1 + int'($urandom % 12);
      fill_list(len);
      setup(len, cp, cd, sp, sd, 2, n);
      run("R1 R4 strobe", 0, 1'b0);
    end

    // high word alone must not change the conversion period
    fill_list(3);
    setup(3, 0, 4, 0, 6, 2, 7);
    par_wr(1, 3);
    run("R2 strobe", 0, 1'b0);

    // divider zero counts as one
    setup(3, 1, 0, 0, 3, 2, 7);
    run("R3 strobe", 0, 1'b0);

    // writes and start while busy are ignored
    fill_list(3);
    setup(3, 0, 2, 0, 3, 2, 8);
    run("R10 strobe", 0, 1'b1);

    // unlimited count, then stop colliding with start
    setup(2, 0, 2, 0, 2, 2, 0);
    run("R8 unlimited", 60, 1'b0);
    stop = 1'b1; start = 1'b1;
    @(negedge clk);
    stop = 1'b0; start = 1'b0;
    chk("R9 busy", int'(busy), 0);
    idle_check("R9 idle", 40);

    // overrun: scan period 8 against a 4-entry burst of period 8
    fill_list(4);
    setup(4, 0, 4, 0, 2, 2, 0);
    pulse_start();
    for (int e = 0; e <= 48; e++) begin
      if (e == 8) begin
        chk("R4 first", int'(conv_stb), 1);
        chk("R5 first", int'(conv_chan), int'(mir[0][5:0]));
      end
      if (e == 15) chk("R7 before", int'(overrun), 0);
      if (e == 16) begin
        chk("R7 set", int'(overrun), 1);
        chk("R7 burst kept", int'(conv_chan), int'(mir[1][5:0]));
      end
      if (e == 40) begin
        chk("R7 next burst", int'(conv_stb), 1);
        chk("R7 next entry", int'(conv_chan), int'(mir[0][5:0]));
        chk("R7 next gain", int'(conv_gain), int'(mir[0][7:6]));
      end
      if (e == 44) chk("R7 gap", int'(conv_stb), 0);
      @(negedge clk);
    end
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    @(negedge clk);
    chk("R7 sticky", int'(overrun), 1);
    setup(2, 0, 2, 0, 2, 2, 3);
    pulse_start();
    chk("R7 cleared", int'(overrun), 0);
    repeat (40) @(negedge clk);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule